// File: doc/BRIEF.md
# Video Control Register Bank with Serial Write Port

This block is the write-only serial control port of a video processing datapath. It watches an oversampled two-wire bus (SCL and SDA, sampled by the system clock), finds START and STOP conditions, and answers only when the first byte carries the fixed 7-bit device address 1000100 with the write bit clear (0x88). The second byte selects one of sixteen 8-bit registers. The bytes after it carry data. Each accepted byte is acknowledged by pulling SDA low during the ninth clock.

A bit in control register 0x0C chooses how data is written. When the bit is clear, writes take effect at once, and further data bytes in the same transfer go to consecutive registers, wrapping from 0x0F to 0x00. When the bit is set, a transfer carries a single data byte. That byte waits in a shadow buffer and is copied into the live register on the next vertical-blank strobe. While the copy is waiting, the port refuses all data.

The live register contents leave the block as a flat vector, together with the control bits decoded from registers 0x0C, 0x0D and 0x0E. An active-low supply-fail reset returns every register to 0x01.

Top module: `vid_ctrl_regbank`

## Requirements
- R1: While reset is asserted, and after it is released, all sixteen registers read 0x01 and the SDA pull-low output is inactive.
- R2: The block acknowledges a first byte of 0x88 only. Any other first byte gets no acknowledge, and every later byte of that transfer is ignored and left unacknowledged.
- R3: The block acknowledges a subaddress byte of 0x00 to 0x0F. A larger value gets no acknowledge, and the data bytes that follow it are ignored.
- R4: In immediate mode, a data byte changes its register within a few clocks of the falling SCL edge that ends the byte. Registers 0x00 to 0x06 and 0x0A keep only data bits [5:0] and read 0 in bits [7:6]. Registers 0x0C to 0x0E keep the full byte.
- R5: In immediate mode, each further data byte in a transfer goes to the next subaddress, and the subaddress wraps from 0x0F back to 0x00.
- R6: Subaddresses 0x07, 0x08, 0x09, 0x0B and 0x0F are acknowledged, but they always read 0x01.
- R7: Decoded outputs are as follows. From register 0x0C: bit 7 gives two-level sandcastle, bit 5 gives buffered mode, bit 3 gives the NTSC matrix. From register 0x0D: bit 4 gives cut-off control off, bit 3 gives switch-2 disable, bit 2 gives switch-2 on, bit 1 gives switch-1 disable, bit 0 gives switch-1 on. From register 0x0E: bit 5 gives output clamp mode.
- R8: In buffered mode, the first data byte is acknowledged and the live register keeps its old value until the next vertical-blank strobe, which copies the byte in. A second data byte in the same transfer gets no acknowledge and is dropped.
- R9: While a buffered byte waits for its copy, the block still acknowledges its address and a valid subaddress. It acknowledges no data byte, and no register changes until the strobe has copied the waiting byte.
- R10: A START or STOP in the middle of a byte abandons that byte. After a START, the next byte is treated as an address byte.
- R11: SDA is pulled low only during the acknowledge clock of an accepted byte. The pull changes only while SCL is low, and it is released after the falling SCL edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low supply-fail reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| vblank_i | input | 1 | One-clock vertical-blank strobe |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | 128 | Live registers, register n in bits [8n+7:8n] |
| sc_two_level_o | output | 1 | Two-level sandcastle select |
| buf_mode_o | output | 1 | Blank-synchronized buffering enabled |
| ntsc_matrix_o | output | 1 | NTSC matrix selected |
| cutoff_off_o | output | 1 | Automatic cut-off control disabled |
| sw2_disable_o | output | 1 | Fast switch 2 input disabled |
| sw2_force_o | output | 1 | Fast switch 2 forced on |
| sw1_disable_o | output | 1 | Fast switch 1 input disabled |
| sw1_force_o | output | 1 | Fast switch 1 forced on |
| clamp_mode_o | output | 1 | Output clamp mode |

## Verification
The hardest state to reach is a buffered byte waiting for its copy. Reaching it takes three steps: enable buffering through an immediate write to register 0x0C, send a buffered transfer, and then send a further full transfer before any strobe arrives. The bench does exactly this. It then checks that the address and subaddress are still acknowledged, that the data byte is refused, and that both registers keep their old values. Only then does it pulse the strobe, and it repeats the write to show the refusal has lifted. Mid-byte aborts are reached by clocking half a byte and then forcing a START or a STOP.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int REG_W  = 8;
  localparam int N_REGS = 16;
  localparam int IDX_W  = $clog2(N_REGS);
  localparam int BIT_W  = $clog2(REG_W + 1);
  localparam logic [6:0]       DEV_ADDR = 7'b1000100;
  localparam logic [REG_W-1:0] RST_VAL  = 8'h01;
  localparam logic [REG_W-1:0] SIX_MASK = 8'h3F;
  localparam int SA_CTRL1 = 12;
  localparam int SA_CTRL2 = 13;
  localparam int SA_CTRL3 = 14;

  typedef enum logic [1:0] {PH_IDLE, PH_BITS, PH_ACK} rx_phase_e;

  function automatic logic sa_reserved(input logic [IDX_W-1:0] a);
    return (a == 4'h7) || (a == 4'h8) || (a == 4'h9) || (a == 4'hB) || (a == 4'hF);
  endfunction

  function automatic logic sa_six_bit(input logic [IDX_W-1:0] a);
    return (a <= 4'h6) || (a == 4'hA);
  endfunction
endpackage

// File: rtl/vcr_sync.sv
module vcr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '1;
      prev_q <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign q    = stg[STAGES-1];
  assign rise = q & ~prev_q;
  assign fall = ~q & prev_q;
endmodule

// File: rtl/vcr_i2c_rx.sv
module vcr_i2c_rx
  import vcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_q,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             buf_en,
  input  logic             pending,
  output logic             sda_pull,
  output logic             wr_imm,
  output logic             wr_buf,
  output logic [IDX_W-1:0] wr_addr,
  output logic [REG_W-1:0] wr_data
);
  rx_phase_e        phase_q, phase_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [REG_W-1:0] sh_q, sh_n;
  logic [1:0]       byte_q, byte_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic             pull_q, pull_n;
  logic             drop_q, drop_n;
  logic             nine_q, nine_n;
  logic             byte_ok;

  always_comb begin
    phase_n = phase_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    byte_n  = byte_q;
    ptr_n   = ptr_q;
    pull_n  = pull_q;
    drop_n  = drop_q;
    nine_n  = nine_q;
    byte_ok = 1'b0;
    wr_imm  = 1'b0;
    wr_buf  = 1'b0;
    wr_addr = ptr_q;
    wr_data = sh_q;
    if (start_det || stop_det) begin
      phase_n = start_det ? PH_BITS : PH_IDLE;
      bit_n   = '0;
      byte_n  = '0;
      pull_n  = 1'b0;
      drop_n  = 1'b0;
      nine_n  = 1'b0;
    end else begin
      case (phase_q)
        PH_BITS: begin
          if (scl_rise && (bit_q < BIT_W'(REG_W))) begin
            sh_n  = {sh_q[REG_W-2:0], sda_q};
            bit_n = bit_q + 1'b1;
          end else if (scl_fall && (bit_q == BIT_W'(REG_W))) begin
            case (byte_q)
              2'd0: byte_ok = (sh_q == {DEV_ADDR, 1'b0});
              2'd1: begin
                byte_ok = (sh_q < REG_W'(N_REGS));
                if (byte_ok) ptr_n = sh_q[IDX_W-1:0];
              end
              2'd2: begin
                if (!pending) begin
                  byte_ok = 1'b1;
                  if (buf_en) begin
                    wr_buf = 1'b1;
                  end else begin
                    wr_imm = 1'b1;
                    ptr_n  = ptr_q + 1'b1;
                  end
                end
              end
              default: begin
                if (!pending && !buf_en) begin
                  byte_ok = 1'b1;
                  wr_imm  = 1'b1;
                  ptr_n   = ptr_q + 1'b1;
                end
              end
            endcase
            pull_n  = byte_ok;
            drop_n  = !byte_ok;
            nine_n  = 1'b0;
            bit_n   = '0;
            phase_n = PH_ACK;
            if (byte_ok && (byte_q != 2'd3)) byte_n = byte_q + 1'b1;
          end
        end
        PH_ACK: begin
          if (scl_rise) begin
            nine_n = 1'b1;
          end else if (scl_fall && nine_q) begin
            pull_n  = 1'b0;
            nine_n  = 1'b0;
            phase_n = drop_q ? PH_IDLE : PH_BITS;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      drop_q  <= 1'b0;
      nine_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      byte_q  <= byte_n;
      ptr_q   <= ptr_n;
      pull_q  <= pull_n;
      drop_q  <= drop_n;
      nine_q  <= nine_n;
    end
  end

  assign sda_pull = pull_q;

  assert_pull_in_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (phase_q == PH_ACK));
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_q);
  assert_ack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACK && nine_q && scl_fall) |=> !pull_q);
  assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_q == '0 && byte_q == '0 && phase_q == PH_BITS));
  assert_no_write_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !(wr_imm || wr_buf));
endmodule

// File: rtl/vcr_regfile.sv
module vcr_regfile
  import vcr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_imm,
  input  logic                    wr_buf,
  input  logic [IDX_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic                    vblank,
  output logic [N_REGS*REG_W-1:0] live,
  output logic                    pending
);
  logic             pend_q, pend_n;
  logic [IDX_W-1:0] sa_q, sa_n;
  logic [REG_W-1:0] sd_q, sd_n;
  logic             commit;

  assign commit = pend_q && vblank;

  always_comb begin
    pend_n = pend_q;
    sa_n   = sa_q;
    sd_n   = sd_q;
    if (commit) begin
      pend_n = 1'b0;
    end else if (wr_buf) begin
      pend_n = 1'b1;
      sa_n   = wr_addr;
      sd_n   = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sa_q   <= '0;
      sd_q   <= RST_VAL;
    end else begin
      pend_q <= pend_n;
      sa_q   <= sa_n;
      sd_q   <= sd_n;
    end
  end

  assign pending = pend_q;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    localparam logic RSV = sa_reserved(IDX_W'(r));
    localparam logic [REG_W-1:0] KEEP = sa_six_bit(IDX_W'(r)) ? SIX_MASK : '1;
    if (RSV) begin : g_fixed
      assign live[r*REG_W +: REG_W] = RST_VAL;
    end else begin : g_store
      logic [REG_W-1:0] val_q, val_n;
      logic             val_en;
      always_comb begin
        val_en = 1'b0;
        val_n  = val_q;
        if (commit && (sa_q == IDX_W'(r))) begin
          val_en = 1'b1;
          val_n  = sd_q & KEEP;
        end else if (wr_imm && (wr_addr == IDX_W'(r))) begin
          val_en = 1'b1;
          val_n  = wr_data & KEEP;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else if (val_en) val_q <= val_n;
      end
      assign live[r*REG_W +: REG_W] = val_q;
    end
  end

  assert_commit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && vblank) |=> !pend_q);
  assert_live_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !vblank) |=> $stable(live));
  assert_single_buffer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_buf |-> !pend_q);
endmodule

// File: rtl/vid_ctrl_regbank.sv
module vid_ctrl_regbank
  import vcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    vblank_i,
  output logic                    sda_pull_o,
  output logic [N_REGS*REG_W-1:0] regs_o,
  output logic                    sc_two_level_o,
  output logic                    buf_mode_o,
  output logic                    ntsc_matrix_o,
  output logic                    cutoff_off_o,
  output logic                    sw2_disable_o,
  output logic                    sw2_force_o,
  output logic                    sw1_disable_o,
  output logic                    sw1_force_o,
  output logic                    clamp_mode_o
);
  logic [1:0]       bus_q, bus_rise, bus_fall;
  logic             start_det, stop_det;
  logic             wr_imm, wr_buf, pending;
  logic [IDX_W-1:0] wr_addr;
  logic [REG_W-1:0] wr_data;
  logic [REG_W-1:0] ctrl1, ctrl2, ctrl3;

  vcr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_i, scl_i}),
    .q(bus_q), .rise(bus_rise), .fall(bus_fall)
  );

  assign start_det = bus_q[0] && !bus_rise[0] && bus_fall[1];
  assign stop_det  = bus_q[0] && !bus_rise[0] && bus_rise[1];

  vcr_i2c_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .scl_q(bus_q[0]), .scl_rise(bus_rise[0]), .scl_fall(bus_fall[0]),
    .sda_q(bus_q[1]), .start_det(start_det), .stop_det(stop_det),
    .buf_en(buf_mode_o), .pending(pending),
    .sda_pull(sda_pull_o), .wr_imm(wr_imm), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  vcr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_imm(wr_imm), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data), .vblank(vblank_i),
    .live(regs_o), .pending(pending)
  );

  assign ctrl1 = regs_o[SA_CTRL1*REG_W +: REG_W];
  assign ctrl2 = regs_o[SA_CTRL2*REG_W +: REG_W];
  assign ctrl3 = regs_o[SA_CTRL3*REG_W +: REG_W];

  assign sc_two_level_o = ctrl1[7];
  assign buf_mode_o     = ctrl1[5];
  assign ntsc_matrix_o  = ctrl1[3];
  assign cutoff_off_o   = ctrl2[4];
  assign sw2_disable_o  = ctrl2[3];
  assign sw2_force_o    = ctrl2[2];
  assign sw1_disable_o  = ctrl2[1];
  assign sw1_force_o    = ctrl2[0];
  assign clamp_mode_o   = ctrl3[5];
endmodule

// File: tb/tb_vid_ctrl_regbank.sv
module tb_vid_ctrl_regbank;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n, scl_drv, sda_drv, vblank;
  logic sda_line;
  logic sda_pull;
  logic [127:0] regs;
  logic sc2, bufm, ntsc, coff, s2d, s2f, s1d, s1f, clmp;

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  vid_ctrl_regbank dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .vblank_i(vblank),
    .sda_pull_o(sda_pull), .regs_o(regs),
    .sc_two_level_o(sc2), .buf_mode_o(bufm), .ntsc_matrix_o(ntsc),
    .cutoff_off_o(coff), .sw2_disable_o(s2d), .sw2_force_o(s2f),
    .sw1_disable_o(s1d), .sw1_force_o(s1f), .clamp_mode_o(clmp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hold_until = 0;

  int m_reg [16];
  int m_byte_n = 0;
  int m_ptr = 0;
  bit m_dead = 1;
  bit m_pend = 0;
  int m_sa = 0;
  int m_sd = 0;

  function automatic void model_apply(input int a, input int d);
    if (a == 7 || a == 8 || a == 9 || a == 11 || a == 15) return;
    if (a <= 6 || a == 10) m_reg[a] = d & 8'h3F;
    else m_reg[a] = d & 8'hFF;
  endfunction

  function automatic bit model_byte(input logic [7:0] b);
    bit ok = 0;
    if (m_dead) return 0;
    if (m_byte_n == 0) ok = (b == 8'h88);
    else if (m_byte_n == 1) begin
      ok = (b < 16);
      if (ok) m_ptr = int'(b);
    end else if (m_pend) ok = 0;
    else if (m_reg[12][5]) begin
      if (m_byte_n == 2) begin
        ok = 1; m_pend = 1; m_sa = m_ptr; m_sd = int'(b);
      end
    end else begin
      ok = 1; model_apply(m_ptr, int'(b)); m_ptr = (m_ptr + 1) % 16;
    end
    if (!ok) m_dead = 1;
    m_byte_n++;
    return ok;
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_reg(input int a, input int exp, input string req);
    check(int'(regs[a*8 +: 8]) == exp, req, int'(regs[a*8 +: 8]), exp);
  endtask

  // Reference comparison of all live registers on every clock (R4 model)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cyc >= hold_until) begin
      checks++;
      for (int r = 0; r < 16; r++) begin
        if (int'(regs[r*8 +: 8]) != m_reg[r]) begin
          errors++;
          $display("FAIL R4 cycle %0d reg %0d actual %0h expected %0h", cyc, r, regs[r*8 +: 8], m_reg[r]);
          break;
        end
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b0; qwait();
    m_byte_n = 0; m_dead = 0;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b1; qwait();
    sda_drv = 1'b1; qwait();
    m_dead = 1;
  endtask

  task automatic half_byte(input logic [7:0] b);
    for (int i = 7; i >= 4; i--) begin
      sda_drv = b[i]; qwait(); scl_drv = 1'b1; qwait(); qwait(); scl_drv = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    bit exp_ack = 0;
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; qwait(); scl_drv = 1'b1; qwait();
      if (i == 3) check(sda_pull == 1'b0, "R11 no pull during data bit", int'(sda_pull), 0);
      qwait(); scl_drv = 1'b0;
      if (i == 0) begin
        exp_ack = model_byte(b);
        hold_until = cyc + 6;
      end
      qwait();
    end
    sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait();
    got = sda_pull;
    qwait(); scl_drv = 1'b0; qwait();
    check(got == exp_ack, req, int'(got), int'(exp_ack));
    check(sda_pull == 1'b0, "R11 release after ninth clock", int'(sda_pull), 0);
  endtask

  task automatic pulse_vblank();
    @(negedge clk);
    vblank = 1'b1;
    if (m_pend) begin
      model_apply(m_sa, m_sd);
      m_pend = 0;
    end
    hold_until = cyc + 3;
    @(negedge clk);
    vblank = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) m_reg[r] = 1;
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; vblank = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(regs[7:0]) == 1 && sda_pull == 1'b0, "R1 during reset", int'(regs[7:0]), 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 16; r++) check_reg(r, 1, "R1 reset value");
    check(sda_pull == 1'b0, "R1 pull idle", int'(sda_pull), 0);
    check({sc2, bufm, ntsc, coff, s2d, s2f, s1d, s1f, clmp} == 9'b000000010,
          "R7 decoded reset", int'({sc2, bufm, ntsc, coff, s2d, s2f, s1d, s1f, clmp}), 2);

    // R2 wrong addresses ignored
    bus_start(); send_byte(8'h89, "R2 read bit nack"); send_byte(8'h00, "R2 ignored");
    send_byte(8'h15, "R2 ignored data"); bus_stop();
    bus_start(); send_byte(8'h90, "R2 other address nack"); send_byte(8'h00, "R2 ignored");
    bus_stop();
    check_reg(0, 1, "R2 reg0 untouched");

    // R4 immediate write with mask, R5 burst
    bus_start(); send_byte(8'h88, "R2 address ack"); send_byte(8'h00, "R3 subaddress ack");
    send_byte(8'hFF, "R4 data ack"); send_byte(8'hAA, "R5 burst ack"); bus_stop();
    check_reg(0, 8'h3F, "R4 six-bit mask");
    check_reg(1, 8'h2A, "R5 next subaddress");

    // R3 subaddress out of range
    bus_start(); send_byte(8'h88, "R2 address ack"); send_byte(8'h10, "R3 subaddress nack");
    send_byte(8'h05, "R3 data ignored"); bus_stop();
    check_reg(0, 8'h3F, "R3 reg0 unchanged");

    // R5 wrap, R6 reserved 0x0F, R7 clamp
    bus_start(); send_byte(8'h88, "R2 address ack"); send_byte(8'h0E, "R3 subaddress ack");
    send_byte(8'h20, "R4 ack"); send_byte(8'h77, "R6 reserved ack"); send_byte(8'h12, "R5 wrap ack");
    bus_stop();
    check_reg(0, 8'h12, "R5 wrap to zero");
    check_reg(15, 1, "R6 reserved 0F");
    check(clmp == 1'b1, "R7 clamp mode", int'(clmp), 1);

    // R6 reserved 07..09, 0B; R4 0x0A mask
    bus_start(); send_byte(8'h88, "R2 address ack"); send_byte(8'h07, "R3 ack");
    send_byte(8'h55, "R6 ack 07"); send_byte(8'h55, "R6 ack 08"); send_byte(8'h55, "R6 ack 09");
    send_byte(8'hC5, "R4 ack 0A"); send_byte(8'hFF, "R6 ack 0B"); bus_stop();
    check_reg(7, 1, "R6 07"); check_reg(8, 1, "R6 08"); check_reg(9, 1, "R6 09");
    check_reg(11, 1, "R6 0B"); check_reg(10, 8'h05, "R4 0A mask");

    // R7 decoded control bits
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h0D, "R3 ack");
    send_byte(8'h1E, "R4 ack"); bus_stop();
    check({coff, s2d, s2f, s1d, s1f} == 5'b11110, "R7 control 2 bits",
          int'({coff, s2d, s2f, s1d, s1f}), 5'b11110);
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h0C, "R3 ack");
    send_byte(8'h88, "R4 ack"); bus_stop();
    check({sc2, bufm, ntsc} == 3'b101, "R7 control 1 bits", int'({sc2, bufm, ntsc}), 3'b101);
    check_reg(12, 8'h88, "R4 full byte kept");

    // R8 enable buffering
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h0C, "R3 ack");
    send_byte(8'hA8, "R4 ack"); bus_stop();
    check(bufm == 1'b1, "R7 buffered mode bit", int'(bufm), 1);
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h03, "R3 ack");
    send_byte(8'h2B, "R8 first data ack"); send_byte(8'h11, "R8 second data nack"); bus_stop();
    repeat (40) @(negedge clk);
    check_reg(3, 1, "R8 held until blank");

    // R9 pending refuses data
    bus_start(); send_byte(8'h88, "R9 address still ack"); send_byte(8'h04, "R9 subaddress still ack");
    send_byte(8'h10, "R9 data refused"); bus_stop();
    check_reg(4, 1, "R9 reg4 unchanged");
    pulse_vblank();
    check_reg(3, 8'h2B, "R8 committed at blank");
    check_reg(4, 1, "R9 refused byte lost");
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h04, "R3 ack");
    send_byte(8'h10, "R9 accepted after blank"); bus_stop();
    pulse_vblank();
    check_reg(4, 8'h10, "R8 second commit");

    // R10 abort by START mid byte
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h05, "R3 ack");
    half_byte(8'h3C);
    bus_start(); send_byte(8'h88, "R10 address after restart"); send_byte(8'h05, "R3 ack");
    send_byte(8'h21, "R10 data after restart"); bus_stop();
    pulse_vblank();
    check_reg(5, 8'h21, "R10 restart write");
    // R10 abort by STOP mid byte
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h06, "R3 ack");
    half_byte(8'h2F); bus_stop();
    pulse_vblank();
    check_reg(6, 1, "R10 stop abort");

    // back to immediate mode, burst again
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h0C, "R3 ack");
    send_byte(8'h00, "R8 buffered control write"); bus_stop();
    check(bufm == 1'b1, "R8 mode held until blank", int'(bufm), 1);
    pulse_vblank();
    check(bufm == 1'b0, "R8 mode committed", int'(bufm), 0);
    bus_start(); send_byte(8'h88, "R2 ack"); send_byte(8'h01, "R3 ack");
    send_byte(8'h0A, "R5 ack"); send_byte(8'h0B, "R5 ack"); bus_stop();
    check_reg(1, 8'h0A, "R5 burst first"); check_reg(2, 8'h0B, "R5 burst second");

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule